// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block forms the next control-store address of a multicycle processor's microcoded controller. A 4-bit microaddress register holds the current control step. On every rising clock edge it loads one of four candidates: zero, the current address plus one, or the output of one of two opcode-indexed dispatch tables. The first table is consulted at the decode step, where all instruction classes fan out. The second is consulted at the address-calculation step, where loads and stores part ways.

The choice among the four candidates comes from a 2-bit sequencing field, `addr_sel`. The surrounding control store supplies it from the control word of the current microaddress. The rest of the control word and the datapath are outside this block. If a dispatch is requested for an opcode that has no entry in the selected table, the sequencer falls back to microaddress 0. It also raises `illegal_dispatch` for that one cycle, so the surrounding logic can raise an exception.

All pins are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: the block accepts `opcode` and `addr_sel` on every edge.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next `uaddr` is 0 and `illegal_dispatch` is 0 (synchronous reset).
- R2: With `addr_sel` = 2'b00 the next `uaddr` is 0 whatever the opcode, and `illegal_dispatch` is 0.
- R3: With `addr_sel` = 2'b11 the next `uaddr` is the current `uaddr` plus 1 modulo 16 whatever the opcode, and `illegal_dispatch` is 0.
- R4: With `addr_sel` = 2'b01 the first table applies: opcode 6'h00 (register-register) gives 6, 6'h02 (jump) gives 9, 6'h04 (branch-equal) gives 8, 6'h0D (or-immediate) gives 10, and 6'h23 (load) and 6'h2B (store) both give 2.
- R5: With `addr_sel` = 2'b10 the second table applies: opcode 6'h23 (load) gives 3 and 6'h2B (store) gives 5.
- R6: A dispatch (`addr_sel` 2'b01 or 2'b10) on an opcode missing from the selected table makes the next `uaddr` 0 and sets `illegal_dispatch` high for exactly that cycle. The flag clears at the next edge unless another unmapped dispatch occurs.
- R7: The address register updates on every rising edge. When `addr_sel` follows the per-state sequencing field, a full pass returns to 0 after a fixed number of steps. The fields are: increment in states 0, 3, 6 and 10; first dispatch in state 1; second dispatch in state 2; zero in states 4, 5, 7, 8, 9 and 11. The steps are load 0-1-2-3-4, store 0-1-2-5, register-register 0-1-6-7, or-immediate 0-1-10-11, branch-equal 0-1-8 and jump 0-1-9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode of the instruction being executed |
| addr_sel | input | 2 | Sequencing field of the current control word: 00 zero, 01 first table, 10 second table, 11 increment |
| uaddr | output | 4 | Current microaddress |
| illegal_dispatch | output | 1 | High for one cycle after a dispatch on an unmapped opcode |

## Verification
A wrong entry in either dispatch table, or a wrong select decode, shows on `uaddr` at the very next rising edge after the offending `addr_sel`/`opcode` pair. A stuck or mis-wrapping incrementer shows within one edge of an increment from the affected state. The sweep starts from every one of the sixteen microaddresses and applies all four select codes with all 64 opcodes. A fault in illegal detection shows on `illegal_dispatch` in that same cycle, and a flag that fails to clear shows one edge later.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'b00,
    SEL_DISP1 = 2'b01,
    SEL_DISP2 = 2'b10,
    SEL_INCR  = 2'b11
  } sel_e;

  localparam logic [5:0] OP_RREG  = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BREQ  = 6'h04;
  localparam logic [5:0] OP_ORIMM = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

endpackage

// File: rtl/mseq_dispatch.sv
module mseq_dispatch #(
  parameter int AW    = 4,
  parameter int OPW   = 6,
  parameter int STAGE = 1
) (
  input  logic [OPW-1:0] opcode,
  output logic           hit,
  output logic [AW-1:0]  target
);
  import mseq_pkg::*;

  generate
    if (STAGE == 1) begin : g_decode_table
      always_comb begin
        hit    = 1'b1;
        target = '0;
        case (opcode)
          OP_RREG:  target = AW'(6);
          OP_JUMP:  target = AW'(9);
          OP_BREQ:  target = AW'(8);
          OP_ORIMM: target = AW'(10);
          OP_LOAD,
          OP_STORE: target = AW'(2);
          default:  hit    = 1'b0;
        endcase
      end
    end else begin : g_memop_table
      always_comb begin
        hit    = 1'b1;
        target = '0;
        case (opcode)
          OP_LOAD:  target = AW'(3);
          OP_STORE: target = AW'(5);
          default:  hit    = 1'b0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/mseq_incr.sv
module mseq_incr #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  assign nxt = cur + AW'(1);
endmodule

// File: rtl/mseq_addr_mux.sv
module mseq_addr_mux #(
  parameter int AW = 4
) (
  input  logic [1:0]    sel,
  input  logic          d1_hit,
  input  logic [AW-1:0] d1_tgt,
  input  logic          d2_hit,
  input  logic [AW-1:0] d2_tgt,
  input  logic [AW-1:0] inc_addr,
  output logic [AW-1:0] next_addr,
  output logic          bad_dispatch
);
  import mseq_pkg::*;

  always_comb begin
    next_addr    = '0;
    bad_dispatch = 1'b0;
    case (sel_e'(sel))
      SEL_ZERO:  next_addr = '0;
      SEL_DISP1: begin
        next_addr    = d1_hit ? d1_tgt : '0;
        bad_dispatch = ~d1_hit;
      end
      SEL_DISP2: begin
        next_addr    = d2_hit ? d2_tgt : '0;
        bad_dispatch = ~d2_hit;
      end
      SEL_INCR:  next_addr = inc_addr;
      default:   next_addr = '0;
    endcase
  end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer #(
  parameter int AW  = 4,
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic [1:0]     addr_sel,
  output logic [AW-1:0]  uaddr,
  output logic           illegal_dispatch
);

  logic          d1_hit, d2_hit, bad_dispatch;
  logic [AW-1:0] d1_tgt, d2_tgt, inc_addr, next_addr;

  mseq_dispatch #(.AW(AW), .OPW(OPW), .STAGE(1)) u_disp_decode (
    .opcode(opcode), .hit(d1_hit), .target(d1_tgt)
  );

  mseq_dispatch #(.AW(AW), .OPW(OPW), .STAGE(2)) u_disp_memop (
    .opcode(opcode), .hit(d2_hit), .target(d2_tgt)
  );

  mseq_incr #(.AW(AW)) u_incr (
    .cur(uaddr), .nxt(inc_addr)
  );

  mseq_addr_mux #(.AW(AW)) u_mux (
    .sel(addr_sel),
    .d1_hit(d1_hit), .d1_tgt(d1_tgt),
    .d2_hit(d2_hit), .d2_tgt(d2_tgt),
    .inc_addr(inc_addr),
    .next_addr(next_addr),
    .bad_dispatch(bad_dispatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr            <= '0;
      illegal_dispatch <= 1'b0;
    end else begin
      uaddr            <= next_addr;
      illegal_dispatch <= bad_dispatch;
    end
  end

endmodule

// File: rtl/mseq_sequencer_chk.sv
module mseq_sequencer_chk #(
  parameter int AW  = 4,
  parameter int OPW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] opcode,
  input logic [1:0]     addr_sel,
  input logic [AW-1:0]  uaddr,
  input logic           illegal_dispatch
);
  import mseq_pkg::*;

  // R2
  a_r2_zero_path: assert property (@(posedge clk) disable iff (rst)
    addr_sel == 2'b00 |=> (uaddr == '0) && !illegal_dispatch);

  // R3
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    addr_sel == 2'b11 |=> (uaddr == AW'($past(uaddr) + AW'(1))) && !illegal_dispatch);

  // R4
  a_r4_decode_branch: assert property (@(posedge clk) disable iff (rst)
    (addr_sel == 2'b01 && opcode == OPW'(OP_BREQ)) |=> uaddr == AW'(8));

  // R5
  a_r5_memop_load: assert property (@(posedge clk) disable iff (rst)
    (addr_sel == 2'b10 && opcode == OPW'(OP_LOAD)) |=> uaddr == AW'(3));

  // R6
  a_r6_flag_forces_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_dispatch |-> uaddr == '0);

  // R6
  a_r6_flag_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (illegal_dispatch && (addr_sel == 2'b00 || addr_sel == 2'b11)) |=> !illegal_dispatch);

endmodule

bind mseq_sequencer mseq_sequencer_chk #(.AW(AW), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .addr_sel(addr_sel),
  .uaddr(uaddr), .illegal_dispatch(illegal_dispatch)
);

// File: tb/mseq_sequencer_test.sv
`timescale 1ns/1ps
module mseq_sequencer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [1:0] addr_sel = '0;
  logic [3:0] uaddr;
  logic       illegal_dispatch;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mseq_sequencer uut (
    .clk(clk), .rst(rst), .opcode(opcode), .addr_sel(addr_sel),
    .uaddr(uaddr), .illegal_dispatch(illegal_dispatch)
  );

  // Expected result {flag, addr} from the requirements.
  function automatic logic [4:0] exp_next(input logic [3:0] s, input logic [1:0] sel,
                                          input logic [5:0] op);
    case (sel)
      2'b00: return {1'b0, 4'd0};
      2'b11: return {1'b0, 4'(s + 4'd1)};
      2'b01: case (op)
        6'h00: return {1'b0, 4'd6};
        6'h02: return {1'b0, 4'd9};
        6'h04: return {1'b0, 4'd8};
        6'h0D: return {1'b0, 4'd10};
        6'h23, 6'h2B: return {1'b0, 4'd2};
        default: return {1'b1, 4'd0};
      endcase
      default: case (op)
        6'h23: return {1'b0, 4'd3};
        6'h2B: return {1'b0, 4'd5};
        default: return {1'b1, 4'd0};
      endcase
    endcase
  endfunction

  function automatic logic [1:0] field_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd3, 4'd6, 4'd10: return 2'b11;
      4'd1: return 2'b01;
      4'd2: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] got_a, input logic [3:0] exp_a,
                     input logic got_f, input logic exp_f);
    vectors++;
    if (got_a !== exp_a || got_f !== exp_f) begin
      miscompares++;
      $display("FAIL %s: uaddr=%0d flag=%0b, expected uaddr=%0d flag=%0b",
               req, got_a, got_f, exp_a, exp_f);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #1;
    // R1: reset state
    do_reset();
    chk("R1", uaddr, 4'd0, illegal_dispatch, 1'b0);

    // R1: reset overrides an increment request
    addr_sel = 2'b11; tick(); tick();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1", uaddr, 4'd0, illegal_dispatch, 1'b0);

    // Sweep: every start state, opcode and select code
    for (int s = 0; s < 16; s++) begin
      for (int op = 0; op < 64; op++) begin
        for (int sel = 0; sel < 4; sel++) begin
          logic [4:0] e;
          string req;
          do_reset();
          addr_sel = 2'b11;
          opcode   = 6'(op);
          for (int k = 0; k < s; k++) tick();
          chk("R3", uaddr, 4'(s), illegal_dispatch, 1'b0);
          addr_sel = 2'(sel);
          tick();
          e = exp_next(4'(s), 2'(sel), 6'(op));
          case (sel)
            0: req = "R2";
            1: req = e[4] ? "R6" : "R4";
            2: req = e[4] ? "R6" : "R5";
            default: req = "R3";
          endcase
          chk(req, uaddr, e[3:0], illegal_dispatch, e[4]);
          if (e[4]) begin
            addr_sel = 2'b11;
            tick();
            chk("R6", uaddr, 4'd1, illegal_dispatch, 1'b0);
          end
        end
      end
    end

    // R7: full passes following the per-state sequencing field
    begin
      logic [5:0] ops [6] = '{6'h23, 6'h2B, 6'h00, 6'h0D, 6'h04, 6'h02};
      int         lens[6] = '{5, 4, 4, 4, 3, 3};
      for (int i = 0; i < 6; i++) begin
        int steps;
        logic [3:0] model;
        do_reset();
        opcode = ops[i];
        model  = 4'd0;
        steps  = 0;
        do begin
          logic [4:0] e;
          addr_sel = field_of(model);
          e = exp_next(model, addr_sel, opcode);
          tick();
          model = e[3:0];
          steps++;
          chk("R7", uaddr, model, illegal_dispatch, 1'b0);
        end while (model != 4'd0 && steps < 10);
        vectors++;
        if (steps != lens[i]) begin
          miscompares++;
          $display("FAIL R7: opcode %0h pass took %0d steps, expected %0d", ops[i], steps, lens[i]);
        end
      end
    end

    // R6: back-to-back unmapped dispatches keep the flag high
    do_reset();
    opcode = 6'h3F; addr_sel = 2'b01; tick();
    chk("R6", uaddr, 4'd0, illegal_dispatch, 1'b1);
    addr_sel = 2'b10; tick();
    chk("R6", uaddr, 4'd0, illegal_dispatch, 1'b1);
    addr_sel = 2'b00; tick();
    chk("R6", uaddr, 4'd0, illegal_dispatch, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule